// File: doc/BRIEF.md
# DDR SDRAM Power-Up and Refresh Sequencer

This block takes a double-data-rate SDRAM from the moment reset is released to normal operation and then keeps the memory refreshed. After reset it keeps clock enable low and the command bus deselected for a settling interval. That interval is a parameter sized from the clock frequency: a wait of more than 200 µs. It then raises clock enable and issues NOPs. A precharge-all follows, then loads of the extended mode register and the base mode register, then a fixed number of precharge-all plus auto-refresh pairs. Only then does it raise `ready`.

Once ready, an interval timer marks one refresh as due every `REFI_CYCLES` cycles. This is the average auto-refresh spacing (7.8 µs times the clock frequency, which gives 8192 refreshes per 64 ms). Refreshes that are due but not yet issued are held in a saturating owed-refresh count. `refresh_req` tells the command scheduler that the sequencer wants the bus. When `grant` is seen while idle, the sequencer issues precharge-all, waits the precharge time, issues auto-refresh and waits the refresh recovery time. It repeats this pair without a new grant until nothing is owed. Self-refresh is not driven by this block.

State machine: HOLD (clock enable low) goes to WAKE when the settling count ends. WAKE (NOP) goes to INIT_PRE when the wake count ends. INIT_PRE goes to INIT_PRE_WAIT, then to LOAD_EXT, then LOAD_EXT_WAIT, then LOAD_BASE, then LOAD_BASE_WAIT, and from there to REF_PRE. REF_PRE goes to REF_PRE_WAIT, then to REF_ISSUE, then to REF_WAIT. REF_WAIT goes back to REF_PRE while initial refreshes remain, or while ready and a refresh is owed. Otherwise it goes to IDLE, setting ready on the first such exit. IDLE goes to REF_PRE when a refresh is owed and grant is high.

Top module: `dram_pwrup_refresh`

## Requirements
- R1: For `HOLD_CYCLES` cycles after reset release, `cke` is 0, `cs_n` is 1 and `ready` is 0.
- R2: `cke` then rises and stays 1. For `WAKE_CYCLES` cycles only NOP (`cs_n`=0, `ras_n`=1, `cas_n`=1, `we_n`=1) is issued before the first other command.
- R3: The initial commands come strictly in this order, and nothing else appears: precharge-all ({ras_n,cas_n,we_n}=010 with addr[10]=1); mode load ({ras_n,cas_n,we_n}=000) with ba=1 and addr=`EXT_MODE`; mode load with ba=0 and addr=`BASE_MODE`; then `INIT_REFS` pairs of precharge-all and auto-refresh ({ras_n,cas_n,we_n}=001). After ready, only precharge-all and auto-refresh appear.
- R4: The command after a precharge-all comes exactly `TRP` cycles later. The command after a mode load comes exactly `TMRD` cycles later. The command after an auto-refresh comes no sooner than `TRFC` cycles later.
- R5: `ready` rises exactly `TRFC` cycles after the last initial auto-refresh and stays 1 until reset.
- R6: From the cycle `ready` rises, one refresh becomes owed every `REFI_CYCLES` cycles. `refresh_req` is 1 whenever a refresh is owed and is 0 before ready.
- R7: While idle, a precharge-all is issued in the cycle after `grant` is 1 with a refresh owed. With `grant` low or nothing owed, only NOP is issued.
- R8: The owed count saturates at `DEBT_MAX`. A due tick and an issued refresh in the same cycle cancel. Once started, pairs repeat back-to-back without a further grant until nothing is owed, and no refresh is issued when nothing is owed.
- R9: With `grant` held high, the number of auto-refreshes in a window of N intervals is N±1.
- R10: `refresh_req` stays 1 through the recovery time of the last refresh of a burst and falls exactly `TRFC` cycles after it. It is 0 when idle with nothing owed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| grant | input | 1 | Scheduler hands the command bus to the sequencer |
| cke | output | 1 | Clock enable to the memory |
| cs_n | output | 1 | Chip select, active low |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, active low |
| ba | output | BA_W | Bank address (mode register select) |
| addr | output | ADDR_W | Address; bit AP_BIT selects all-bank precharge |
| ready | output | 1 | Initialization complete |
| refresh_req | output | 1 | Sequencer needs or holds the bus for refresh |

## Verification
The bench drives `grant` during initialization with random values, to show that the power-up order and timing do not depend on it. It then holds grant high for twenty intervals, which measures the average refresh spacing. Next it holds grant low for six intervals and then raises it, which fills the owed count to its limit and shows the burst length and the recovery-time release of `refresh_req`. After that comes a long phase of sparse random grants, where an independent model of the owed count tells a grant in the idle state apart from one during a burst. A final single-cycle grant pulse shows that a started refresh finishes without a held grant.

// File: rtl/dram_seq_pkg.sv
package dram_seq_pkg;

    typedef enum logic [3:0] {
        ST_HOLD,
        ST_WAKE,
        ST_INIT_PRE,
        ST_INIT_PRE_WAIT,
        ST_LOAD_EXT,
        ST_LOAD_EXT_WAIT,
        ST_LOAD_BASE,
        ST_LOAD_BASE_WAIT,
        ST_REF_PRE,
        ST_REF_PRE_WAIT,
        ST_REF_ISSUE,
        ST_REF_WAIT,
        ST_IDLE
    } seq_state_t;

    typedef struct packed {
        logic cs_n;
        logic ras_n;
        logic cas_n;
        logic we_n;
    } cmd_pins_t;

    localparam cmd_pins_t CMD_DESEL = '{cs_n: 1'b1, ras_n: 1'b1, cas_n: 1'b1, we_n: 1'b1};
    localparam cmd_pins_t CMD_NOP   = '{cs_n: 1'b0, ras_n: 1'b1, cas_n: 1'b1, we_n: 1'b1};
    localparam cmd_pins_t CMD_PRE   = '{cs_n: 1'b0, ras_n: 1'b0, cas_n: 1'b1, we_n: 1'b0};
    localparam cmd_pins_t CMD_AREF  = '{cs_n: 1'b0, ras_n: 1'b0, cas_n: 1'b0, we_n: 1'b1};
    localparam cmd_pins_t CMD_MODE  = '{cs_n: 1'b0, ras_n: 1'b0, cas_n: 1'b0, we_n: 1'b0};

endpackage

// File: rtl/refi_timer.sv
module refi_timer #(
    parameter int REFI = 1560
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    output logic tick
);
    localparam int W = (REFI > 2) ? $clog2(REFI) : 1;

    logic [W-1:0] cnt;

    assign tick = en && (cnt == W'(REFI - 1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (en) begin
            cnt <= tick ? '0 : cnt + 1'b1;
        end
    end

    AST_TICK_SPACED: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick); // R6

endmodule

// File: rtl/refresh_debt.sv
module refresh_debt #(
    parameter int DEBT_MAX = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic inc,
    input  logic dec,
    output logic owed
);
    localparam int DW = $clog2(DEBT_MAX + 1);

    logic [DW-1:0] debt;

    assign owed = (debt != '0);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            debt <= '0;
        end else begin
            unique case ({inc, dec})
                2'b10:   if (debt != DW'(DEBT_MAX)) debt <= debt + 1'b1;
                2'b01:   if (debt != '0) debt <= debt - 1'b1;
                default: debt <= debt;
            endcase
        end
    end

    AST_DEBT_CAP: assert property (@(posedge clk) disable iff (!rst_n)
        debt <= DW'(DEBT_MAX)); // R8
    AST_DEBT_CANCEL: assert property (@(posedge clk) disable iff (!rst_n)
        (inc && dec) |=> (debt == $past(debt))); // R8

endmodule

// File: rtl/dram_pwrup_refresh.sv
module dram_pwrup_refresh
    import dram_seq_pkg::*;
#(
    parameter int HOLD_CYCLES = 40000,
    parameter int WAKE_CYCLES = 4,
    parameter int TRP         = 3,
    parameter int TMRD        = 2,
    parameter int TRFC        = 15,
    parameter int REFI_CYCLES = 1560,
    parameter int DEBT_MAX    = 4,
    parameter int INIT_REFS   = 2,
    parameter int ADDR_W      = 13,
    parameter int BA_W        = 2,
    parameter int AP_BIT      = 10,
    parameter logic [ADDR_W-1:0] EXT_MODE  = '0,
    parameter logic [ADDR_W-1:0] BASE_MODE = 13'h0032
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              grant,
    output logic              cke,
    output logic              cs_n,
    output logic              ras_n,
    output logic              cas_n,
    output logic              we_n,
    output logic [BA_W-1:0]   ba,
    output logic [ADDR_W-1:0] addr,
    output logic              ready,
    output logic              refresh_req
);
    localparam int TW  = $clog2(HOLD_CYCLES + WAKE_CYCLES + TRP + TMRD + TRFC + 1);
    localparam int ICW = $clog2(INIT_REFS + 1);

    seq_state_t     state, state_nx;
    logic [TW-1:0]  tmr, tmr_nx;
    logic [ICW-1:0] irefs, irefs_nx;
    logic           ready_nx;
    logic           tick, owed, ref_done;
    cmd_pins_t      cmd;

    refi_timer #(.REFI(REFI_CYCLES)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (ready),
        .tick  (tick)
    );

    assign ref_done = (state == ST_REF_ISSUE) && ready;

    refresh_debt #(.DEBT_MAX(DEBT_MAX)) u_debt (
        .clk   (clk),
        .rst_n (rst_n),
        .inc   (tick),
        .dec   (ref_done),
        .owed  (owed)
    );

    // next-state logic
    always_comb begin
        state_nx = state;
        tmr_nx   = (tmr != '0) ? tmr - 1'b1 : tmr;
        irefs_nx = irefs;
        ready_nx = ready;
        unique case (state)
            ST_HOLD: if (tmr == '0) begin
                state_nx = ST_WAKE;
                tmr_nx   = TW'(WAKE_CYCLES - 1);
            end
            ST_WAKE:           if (tmr == '0) state_nx = ST_INIT_PRE;
            ST_INIT_PRE: begin
                state_nx = ST_INIT_PRE_WAIT;
                tmr_nx   = TW'(TRP - 2);
            end
            ST_INIT_PRE_WAIT:  if (tmr == '0) state_nx = ST_LOAD_EXT;
            ST_LOAD_EXT: begin
                state_nx = ST_LOAD_EXT_WAIT;
                tmr_nx   = TW'(TMRD - 2);
            end
            ST_LOAD_EXT_WAIT:  if (tmr == '0) state_nx = ST_LOAD_BASE;
            ST_LOAD_BASE: begin
                state_nx = ST_LOAD_BASE_WAIT;
                tmr_nx   = TW'(TMRD - 2);
            end
            ST_LOAD_BASE_WAIT: if (tmr == '0) state_nx = ST_REF_PRE;
            ST_REF_PRE: begin
                state_nx = ST_REF_PRE_WAIT;
                tmr_nx   = TW'(TRP - 2);
            end
            ST_REF_PRE_WAIT:   if (tmr == '0) state_nx = ST_REF_ISSUE;
            ST_REF_ISSUE: begin
                state_nx = ST_REF_WAIT;
                tmr_nx   = TW'(TRFC - 2);
                if (!ready) irefs_nx = irefs - 1'b1;
            end
            ST_REF_WAIT: if (tmr == '0) begin
                if (!ready) begin
                    if (irefs == '0) begin
                        state_nx = ST_IDLE;
                        ready_nx = 1'b1;
                    end else begin
                        state_nx = ST_REF_PRE;
                    end
                end else begin
                    state_nx = owed ? ST_REF_PRE : ST_IDLE;
                end
            end
            ST_IDLE:           if (owed && grant) state_nx = ST_REF_PRE;
            default:           state_nx = ST_HOLD;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_HOLD;
            tmr   <= TW'(HOLD_CYCLES - 1);
            irefs <= ICW'(INIT_REFS);
            ready <= 1'b0;
        end else begin
            state <= state_nx;
            tmr   <= tmr_nx;
            irefs <= irefs_nx;
            ready <= ready_nx;
        end
    end

    // outputs
    always_comb begin
        cmd  = CMD_NOP;
        ba   = '0;
        addr = '0;
        unique case (state)
            ST_HOLD:                  cmd = CMD_DESEL;
            ST_INIT_PRE, ST_REF_PRE: begin
                cmd          = CMD_PRE;
                addr[AP_BIT] = 1'b1;
            end
            ST_LOAD_EXT: begin
                cmd  = CMD_MODE;
                ba   = BA_W'(1);
                addr = EXT_MODE;
            end
            ST_LOAD_BASE: begin
                cmd  = CMD_MODE;
                addr = BASE_MODE;
            end
            ST_REF_ISSUE:             cmd = CMD_AREF;
            default:                  cmd = CMD_NOP;
        endcase
    end

    assign cke         = (state != ST_HOLD);
    assign cs_n        = cmd.cs_n;
    assign ras_n       = cmd.ras_n;
    assign cas_n       = cmd.cas_n;
    assign we_n        = cmd.we_n;
    assign refresh_req = ready && (owed || state != ST_IDLE);

    AST_HOLD_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_HOLD) |-> !ready); // R1
    AST_READY_STAYS: assert property (@(posedge clk) disable iff (!rst_n)
        ready |=> ready); // R5
    AST_REF_AFTER_PRE: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_REF_ISSUE) |-> ($past(state) == ST_REF_PRE_WAIT)); // R4
    AST_NO_REQ_EARLY: assert property (@(posedge clk) disable iff (!rst_n)
        !ready |-> !refresh_req); // R6
    AST_REF_NEEDS_DEBT: assert property (@(posedge clk) disable iff (!rst_n)
        ref_done |-> owed); // R8
    AST_IDLE_START_GRANTED: assert property (@(posedge clk) disable iff (!rst_n)
        ((state == ST_REF_PRE) && ($past(state) == ST_IDLE)) |-> $past(grant)); // R7

endmodule

// File: tb/sim_dram_pwrup_refresh.sv
module sim_dram_pwrup_refresh;
    localparam int CLK_PERIOD = 10;
    localparam int HOLD = 200;
    localparam int WAKE = 4;
    localparam int TRP  = 3;
    localparam int TMRD = 2;
    localparam int TRFC = 8;
    localparam int REFI = 64;
    localparam int DMAX = 4;
    localparam int NREF = 2;
    localparam logic [12:0] EXTV  = 13'h0002;
    localparam logic [12:0] BASEV = 13'h0032;

    localparam int C_DES = 0, C_NOP = 1, C_PRE = 2, C_REF = 3, C_MRS = 4, C_OTH = 5, C_WAKE = 6;

    logic        clk, rst_n, grant;
    logic        cke, cs_n, ras_n, cas_n, we_n, ready, refresh_req;
    logic [1:0]  ba;
    logic [12:0] addr;

    dram_pwrup_refresh #(
        .HOLD_CYCLES(HOLD), .WAKE_CYCLES(WAKE), .TRP(TRP), .TMRD(TMRD), .TRFC(TRFC),
        .REFI_CYCLES(REFI), .DEBT_MAX(DMAX), .INIT_REFS(NREF), .ADDR_W(13), .BA_W(2),
        .AP_BIT(10), .EXT_MODE(EXTV), .BASE_MODE(BASEV)
    ) u0 (
        .clk(clk), .rst_n(rst_n), .grant(grant), .cke(cke), .cs_n(cs_n), .ras_n(ras_n),
        .cas_n(cas_n), .we_n(we_n), .ba(ba), .addr(addr), .ready(ready),
        .refresh_req(refresh_req)
    );

    initial clk = 1'b0;
    always #(CLK_PERIOD / 2) clk = ~clk;

    int n_tests = 0;
    int n_fail  = 0;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: got %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    endtask

    function automatic int decode(input logic c, input logic r, input logic a,
                                  input logic w, input logic ap);
        if (c) return C_DES;
        case ({r, a, w})
            3'b111:  return C_NOP;
            3'b010:  return ap ? C_PRE : C_OTH;
            3'b001:  return C_REF;
            3'b000:  return C_MRS;
            default: return C_OTH;
        endcase
    endfunction

    function automatic int init_expect(input int i);
        if (i == 0) return C_PRE;
        if (i == 1 || i == 2) return C_MRS;
        return (((i - 3) % 2) == 0) ? C_PRE : C_REF;
    endfunction

    // monitor state
    int cyc = 0, hold_cnt = 0, init_idx = 0, last_cyc = 0, last_code = C_DES;
    int last_ref = 0, model_debt = 0, rdy_k = 0, ref_count = 0, cmd_count = 0;
    bit cke_seen = 0, ready_seen = 0, pre_since = 0, exp_valid = 0, exp_pre = 0, prev_req = 0;

    always @(negedge clk) begin : monitor
        int code, gap;
        bit idle, inc_now, dec_now;
        if (rst_n) begin
            cyc++;
            code = decode(cs_n, ras_n, cas_n, we_n, addr[10]);
            if (!cke_seen) begin
                if (cke) begin
                    cke_seen = 1;
                    chk(hold_cnt == HOLD, "R1", hold_cnt, HOLD);
                    chk(code == C_NOP, "R2", code, C_NOP);
                    last_cyc  = cyc;
                    last_code = C_WAKE;
                end else begin
                    hold_cnt++;
                    chk(cs_n == 1'b1 && !ready, "R1", cs_n, 1);
                end
            end else begin
                chk(cke == 1'b1, "R2", cke, 1);
                if (code != C_NOP) begin
                    gap = cyc - last_cyc;
                    case (last_code)
                        C_WAKE:  chk(gap == WAKE, "R2", gap, WAKE);
                        C_PRE:   chk(gap == TRP, "R4", gap, TRP);
                        C_MRS:   chk(gap == TMRD, "R4", gap, TMRD);
                        default: chk(gap >= TRFC, "R4", gap, TRFC);
                    endcase
                    if (!ready) begin
                        chk(code == init_expect(init_idx), "R3", code, init_expect(init_idx));
                        if (init_idx == 1)
                            chk(ba == 2'd1 && addr == EXTV, "R3", int'(addr), int'(EXTV));
                        if (init_idx == 2)
                            chk(ba == 2'd0 && addr == BASEV, "R3", int'(addr), int'(BASEV));
                        init_idx++;
                    end else begin
                        chk(code == C_PRE || code == C_REF, "R3", code, C_REF);
                        cmd_count++;
                    end
                    if (code == C_REF) begin
                        last_ref  = cyc;
                        pre_since = 0;
                        if (ready) begin
                            chk(model_debt > 0, "R8", model_debt, 1);
                            ref_count++;
                        end
                    end
                    if (code == C_PRE) pre_since = 1;
                    last_cyc  = cyc;
                    last_code = code;
                end
            end

            if (!ready) chk(!refresh_req, "R6", refresh_req, 0);
            if (ready && !ready_seen) begin
                ready_seen = 1;
                chk(init_idx == 3 + 2 * NREF, "R3", init_idx, 3 + 2 * NREF);
                chk(cyc - last_ref == TRFC, "R5", cyc - last_ref, TRFC);
            end else if (ready_seen) begin
                chk(ready == 1'b1, "R5", ready, 1);
            end

            if (ready) begin
                rdy_k++;
                if (exp_valid) chk((code == C_PRE) == exp_pre, "R7", code, exp_pre ? C_PRE : C_NOP);
                if (model_debt > 0) chk(refresh_req == 1'b1, "R6", refresh_req, 1);
                idle = (cyc - last_ref >= TRFC) && !pre_since;
                if (idle && model_debt == 0) chk(!refresh_req, "R10", refresh_req, 0);
                if (prev_req && !refresh_req)
                    chk(cyc - last_ref == TRFC, "R10", cyc - last_ref, TRFC);
                exp_valid = idle;
                exp_pre   = idle && (model_debt > 0) && grant;
                inc_now   = ((rdy_k % REFI) == 0);
                dec_now   = (code == C_REF);
                if (inc_now && !dec_now && model_debt < DMAX) model_debt++;
                else if (dec_now && !inc_now && model_debt > 0) model_debt--;
                prev_req = refresh_req;
            end
        end
    end

    initial begin : watchdog
        #(CLK_PERIOD * 200000);
        n_tests++;
        n_fail++;
        $display("FAIL R5: watchdog expired, got 0 expected 1");
        finish_run();
    end

    initial begin : stim
        int seed_val, base, n;
        seed_val = $urandom(32'h5eed);
        grant = 1'b0;
        rst_n = 1'b0;
        repeat (3) @(posedge clk);
        #1;
        chk(cke == 1'b0, "R1", cke, 0);
        chk(cs_n == 1'b1, "R1", cs_n, 1);
        chk(ready == 1'b0, "R5", ready, 0);
        chk(refresh_req == 1'b0, "R6", refresh_req, 0);
        rst_n = 1'b1;

        // random grant during power-up must not disturb the sequence (R3)
        while (!ready) begin
            @(posedge clk);
            #1 grant = 1'($urandom_range(0, 1));
        end

        // R9: grant held, average spacing
        grant = 1'b1;
        base = ref_count;
        repeat (20 * REFI) @(posedge clk);
        #1;
        n = ref_count - base;
        chk(n >= 19 && n <= 21, "R9", n, 20);

        // R7/R8: withhold grant, then release it
        grant = 1'b0;
        repeat (40) @(posedge clk);
        #1;
        base = cmd_count;
        repeat (6 * REFI) @(posedge clk);
        #1;
        chk(cmd_count == base, "R7", cmd_count - base, 0);
        chk(refresh_req == 1'b1, "R6", refresh_req, 1);
        grant = 1'b1;
        base = ref_count;
        for (int i = 0; i < 200; i++) begin
            @(posedge clk);
            #1;
            if (!refresh_req) break;
        end
        n = ref_count - base;
        chk(n >= DMAX && n <= DMAX + 1, "R8", n, DMAX);

        // random sparse grants
        for (int i = 0; i < 3000; i++) begin
            @(posedge clk);
            #1 grant = ($urandom_range(0, 3) == 0);
        end

        // drain, then a single-cycle grant pulse must finish the refresh (R8, R10)
        grant = 1'b1;
        repeat (100) @(posedge clk);
        #1 grant = 1'b0;
        for (int i = 0; i < 2 * REFI; i++) begin
            @(posedge clk);
            #1;
            if (refresh_req) break;
        end
        chk(refresh_req == 1'b1, "R6", refresh_req, 1);
        base = ref_count;
        @(posedge clk);
        #1 grant = 1'b1;
        @(posedge clk);
        #1 grant = 1'b0;
        repeat (40) @(posedge clk);
        #1;
        chk(refresh_req == 1'b0, "R10", refresh_req, 0);
        chk(ref_count - base == 1, "R8", ref_count - base, 1);

        finish_run();
    end

endmodule